// File: doc/BRIEF.md
# Keyed user interrupt mask filter

This block holds a 32-bit register that sets a user-mode interrupt mask level. Software writes it through a simple register port. A write changes the 4-bit level field only when the top byte of the write data carries a fixed protection key. Writes that lack the key leave the register unchanged, so a stray store cannot open or close interrupt acceptance by accident.

Every cycle the block also decides whether the interrupt request on its input may be taken. A maskable request passes only when all three of these hold:
- its level is strictly above the user mask level;
- its per-source mask bit, supplied from outside, is clear;
- the processor status-register mask level, also supplied from outside, is below the request's level.

A non-maskable request passes regardless of those conditions. The decision is registered onto a single accept output.

Top module: `umask_filter`

## Requirements
- R1: While `rst` is high at a clock edge, the register is cleared to 0x00000000 and `accept` is cleared to 0. After reset, every read returns 0x00000000 until a keyed write occurs.
- R2: A write (`reg_sel`=1, `reg_we`=1) with `reg_wdata[31:24]`=0xA5 loads `reg_wdata[7:4]` into the level field. A following read returns the level in bits 7:4 and zero in all other bits, including zero in bits 31:24.
- R3: A write whose bits 31:24 differ from 0xA5 leaves the register unchanged.
- R4: A maskable request whose level is below or equal to the user mask level is not accepted.
- R5: With user mask level 0xF, no maskable request is accepted, whatever the level, source mask bit or status-register mask level.
- R6: A maskable request above the user mask level is accepted exactly when `src_masked`=0 and `sr_level` is less than the request level.
- R7: A request with `irq_nmi`=1 is accepted whenever `irq_valid`=1, whatever the mask inputs and the register hold.
- R8: `accept` rises at the clock edge after the cycle in which a qualifying request is presented, not in the same cycle. A request presented in the same cycle as a keyed write is judged against the old level; a request presented in the next cycle is judged against the new level.
- R9: Accepting a request leaves the level field unchanged.
- R10: With `irq_valid`=0, `accept` is 0 on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-on or manual) |
| reg_sel | input | 1 | Register access select |
| reg_we | input | 1 | Write enable, qualified by reg_sel |
| reg_wdata | input | 32 | Write data; bits 31:24 must be the key 0xA5, level in bits 7:4 |
| reg_rdata | output | 32 | Read data while reg_sel is high, else zero |
| irq_valid | input | 1 | Interrupt request present |
| irq_nmi | input | 1 | Request is non-maskable |
| irq_level | input | 4 | Request priority level |
| src_masked | input | 1 | Per-source mask bit, 1 = source disabled |
| sr_level | input | 4 | Status-register interrupt mask level |
| accept | output | 1 | Registered acceptance of the request |

## Verification
The bench checks requests whose level equals the user mask level. A design that used "greater or equal" would accept these.

It sets the level to 0xF and offers a level-0xF request with every other condition favourable. A design that special-cased the top level wrongly would take it.

It presents a request in the same cycle as a keyed write. A design that bypassed the register would judge that request against the new level. Separate cases cover two further faults:
- keys that differ from 0xA5 in a single bit, which catch a key compare that ignores some bits;
- a status-register mask level equal to the request level, which catches a "less or equal" comparison.

// File: rtl/umask_pkg.sv
package umask_pkg;

    localparam int unsigned REG_W    = 32;
    localparam int unsigned LVL_W    = 4;
    localparam int unsigned KEY_W    = 8;
    localparam int unsigned LVL_LSB  = 4;
    localparam int unsigned KEY_LSB  = REG_W - KEY_W;
    localparam logic [KEY_W-1:0] WR_KEY = 8'hA5;
    localparam logic [LVL_W-1:0] LVL_ALL = '1;

    typedef logic [LVL_W-1:0] level_t;

    typedef struct packed {
        logic   valid;
        logic   nmi;
        level_t level;
    } irq_req_t;

    function automatic logic key_matches(input logic [REG_W-1:0] d);
        return d[KEY_LSB +: KEY_W] == WR_KEY;
    endfunction

    function automatic level_t level_of(input logic [REG_W-1:0] d);
        return d[LVL_LSB +: LVL_W];
    endfunction

    function automatic logic [REG_W-1:0] reg_image(input level_t l);
        logic [REG_W-1:0] img;
        img = '0;
        img[LVL_LSB +: LVL_W] = l;
        return img;
    endfunction

endpackage

// File: rtl/umask_reg.sv
module umask_reg
    import umask_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output level_t           user_level
);

    logic   wr_ok;
    level_t level_q;

    assign wr_ok = wr_en && key_matches(wr_data);

    always_ff @(posedge clk) begin
        if (rst)        level_q <= '0;
        else if (wr_ok) level_q <= level_of(wr_data);
    end

    assign user_level = level_q;

    // R2
    keyed_write_loads_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[31:24] == 8'hA5) |=> (user_level == $past(wr_data[7:4])));

    // R3
    unkeyed_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[31:24] != 8'hA5) |=> $stable(user_level));

endmodule

// File: rtl/umask_gate.sv
module umask_gate
    import umask_pkg::*;
(
    input  irq_req_t req,
    input  level_t   user_level,
    input  logic     src_masked,
    input  level_t   sr_level,
    output logic     grant
);

    logic above_user;
    logic above_sr;
    logic maskable_ok;

    always_comb begin
        above_user  = (req.level > user_level) && (user_level != LVL_ALL);
        above_sr    = sr_level < req.level;
        maskable_ok = above_user && !src_masked && above_sr;
        grant       = req.valid && (req.nmi || maskable_ok);
    end

endmodule

// File: rtl/umask_filter.sv
module umask_filter
    import umask_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_sel,
    input  logic        reg_we,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        irq_valid,
    input  logic        irq_nmi,
    input  logic [3:0]  irq_level,
    input  logic        src_masked,
    input  logic [3:0]  sr_level,
    output logic        accept
);

    level_t   user_level;
    irq_req_t req;
    logic     grant;
    logic     accept_q;

    umask_reg u_reg (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (reg_sel && reg_we),
        .wr_data    (reg_wdata),
        .user_level (user_level)
    );

    assign req = '{valid: irq_valid, nmi: irq_nmi, level: irq_level};

    umask_gate u_gate (
        .req        (req),
        .user_level (user_level),
        .src_masked (src_masked),
        .sr_level   (sr_level),
        .grant      (grant)
    );

    always_ff @(posedge clk) begin
        if (rst) accept_q <= 1'b0;
        else     accept_q <= grant;
    end

    assign accept    = accept_q;
    assign reg_rdata = reg_sel ? reg_image(user_level) : '0;

    // R7
    nmi_always_taken_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_valid && irq_nmi) |=> accept);

    // R5
    full_mask_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_valid && !irq_nmi && user_level == 4'hF) |=> !accept);

    // R4
    low_level_blocked_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_valid && !irq_nmi && irq_level <= user_level) |=> !accept);

    // R10
    idle_no_accept_chk: assert property (@(posedge clk) disable iff (rst)
        !irq_valid |=> !accept);

    // R6
    src_masked_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_valid && !irq_nmi && src_masked) |=> !accept);

endmodule

// File: tb/test_umask_filter.sv
module test_umask_filter;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_sel, reg_we;
    logic [31:0] reg_wdata, reg_rdata;
    logic        irq_valid, irq_nmi, src_masked;
    logic [3:0]  irq_level, sr_level;
    logic        accept;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    umask_filter i_umask_filter (
        .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_valid(irq_valid),
        .irq_nmi(irq_nmi), .irq_level(irq_level), .src_masked(src_masked),
        .sr_level(sr_level), .accept(accept)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [31:0] d);
        @(negedge clk);
        reg_sel = 1'b1; reg_we = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_sel = 1'b0; reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic read_check(input string req, input logic [31:0] exp);
        @(negedge clk);
        reg_sel = 1'b1;
        #1 check(req, reg_rdata, exp);
        reg_sel = 1'b0;
    endtask

    task automatic probe(input string req, input logic nmi, input logic [3:0] lvl,
                         input logic sm, input logic [3:0] sr, input logic exp);
        @(negedge clk);
        irq_valid = 1'b1; irq_nmi = nmi; irq_level = lvl; src_masked = sm; sr_level = sr;
        @(negedge clk);
        check(req, {31'b0, accept}, {31'b0, exp});
        irq_valid = 1'b0; irq_nmi = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 accept after reset", {31'b0, accept}, 32'h0);
        read_check("R1 reg after reset", 32'h0);
        probe("R1 level1 at mask0", 1'b0, 4'h1, 1'b0, 4'h0, 1'b1);
    endtask

    task automatic t_write;
        write_reg(32'hA5FF_FF3F);
        read_check("R2 keyed write", 32'h0000_0030);
        write_reg(32'hA4FF_FF9F);
        read_check("R3 key A4 ignored", 32'h0000_0030);
        write_reg(32'h25FF_FF9F);
        read_check("R3 key 25 ignored", 32'h0000_0030);
        @(negedge clk);
        reg_sel = 1'b0; reg_we = 1'b1; reg_wdata = 32'hA500_0090;
        @(negedge clk);
        reg_we = 1'b0;
        read_check("R3 write without select ignored", 32'h0000_0030);
    endtask

    task automatic t_levels;
        write_reg(32'hA500_0050);
        probe("R4 equal level", 1'b0, 4'h5, 1'b0, 4'h0, 1'b0);
        probe("R4 lower level", 1'b0, 4'h2, 1'b0, 4'h0, 1'b0);
        probe("R6 above, all ok", 1'b0, 4'h6, 1'b0, 4'h0, 1'b1);
        probe("R6 source masked", 1'b0, 4'h9, 1'b1, 4'h0, 1'b0);
        probe("R6 sr equal level", 1'b0, 4'h9, 1'b0, 4'h9, 1'b0);
        probe("R6 sr just below", 1'b0, 4'h9, 1'b0, 4'h8, 1'b1);
        probe("R6 sr above", 1'b0, 4'h9, 1'b0, 4'hC, 1'b0);
        read_check("R9 level kept after accept", 32'h0000_0050);
    endtask

    task automatic t_full_mask;
        write_reg(32'hA500_00F0);
        probe("R5 level F blocked", 1'b0, 4'hF, 1'b0, 4'h0, 1'b0);
        probe("R7 nmi under mask F", 1'b1, 4'h0, 1'b1, 4'hF, 1'b1);
        probe("R7 nmi level F", 1'b1, 4'hF, 1'b0, 4'h0, 1'b1);
        @(negedge clk);
        irq_valid = 1'b0; irq_nmi = 1'b1;
        @(negedge clk);
        check("R10 nmi flag without valid", {31'b0, accept}, 32'h0);
        irq_nmi = 1'b0;
    endtask

    task automatic t_timing;
        write_reg(32'hA500_0070);
        @(negedge clk);
        reg_sel = 1'b1; reg_we = 1'b1; reg_wdata = 32'hA500_0030;
        irq_valid = 1'b1; irq_level = 4'h5; src_masked = 1'b0; sr_level = 4'h0;
        #1 check("R8 no same-cycle accept", {31'b0, accept}, 32'h0);
        @(negedge clk);
        reg_sel = 1'b0; reg_we = 1'b0;
        check("R8 old level used in write cycle", {31'b0, accept}, 32'h0);
        @(negedge clk);
        check("R8 new level used next cycle", {31'b0, accept}, 32'h1);
        irq_valid = 1'b0;
        @(negedge clk);
        check("R10 accept drops when idle", {31'b0, accept}, 32'h0);
    endtask

    initial begin
        rst = 1'b1; reg_sel = 0; reg_we = 0; reg_wdata = '0;
        irq_valid = 0; irq_nmi = 0; irq_level = '0; src_masked = 0; sr_level = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_write();
        t_levels();
        t_full_mask();
        t_timing();
        write_reg(32'hA500_0090);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        read_check("R1 reset clears written level", 32'h0);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule